// File: doc/BRIEF.md
# Ping-Pong Dual Timer Sequencer

This block holds two down-counting timers, a short one (A, default 8 bits) and a long one (B, default 16 bits). In alternating mode, each timer's terminal count starts the other one. The two timers therefore run one after the other. With suitable reload values this produces repeating patterns such as a carrier burst followed by a silent gap.

Both timers count on one shared tick from a prescaler. The prescaler runs only while a timer is active.

Software sets the block up through a plain write port that has no back-pressure: every write is taken on the clock edge where `cfg_we` is high. Setting up alternating mode takes three steps:

1. Stop both timers.
2. Put both timers in single-pass mode and select alternating mode; these writes may come in any order.
3. Start timer A by setting its enable bit.

Writing the mode field back to normal ends the alternation.

Top module: `pp_timer_seq`

## Requirements
- R1: After reset both timers are stopped, both timeout flags are 0, the mode is normal and both outputs are 0.
- R2: A timer enabled with reload value N reaches terminal count after N ticks, and a tick occurs every TICK_DIV clocks, counted from the edge that starts the first timer. A reload value of 0 means 2^W ticks.
- R3: A timer's timeout flag is set at every terminal count. It stays set until software writes its control register with bit 2 = 1.
- R4: In single-pass mode (control bit 1 = 1) and normal mode (mode field 2'b00), the timer's enable clears at terminal count and the other timer does not start.
- R5: With control bit 1 = 0, a timer reloads at terminal count and keeps running.
- R6: In alternating mode (mode field 2'b01), a terminal count of A clears A's enable on the same edge that sets B's enable and loads B with its reload value.
- R7: In alternating mode, a terminal count of B starts A in the same way, so the two timers keep alternating and only one of them runs at a time.
- R8: Writing the mode field to 2'b00 during alternation lets the running timer finish its pass; after that neither timer starts again.
- R9: If software clears the running timer's enable (control bit 0 = 0) during alternation, both timers stay stopped.
- R10: Each output equals the timer's initial-level bit (control bit 3) while that timer is stopped, and equals the inverse of that bit while it runs.
- R11: Write addresses are: 0 = A reload, 1 = B reload, 2 = A control, 3 = B control, 4 = mode field in bits 1:0. A write takes effect on the edge where `cfg_we` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_we | input | 1 | Write strobe, always accepted |
| cfg_addr | input | 3 | Register select |
| cfg_wdata | input | B_W | Write data |
| a_run | output | 1 | Timer A enable bit |
| b_run | output | 1 | Timer B enable bit |
| a_timeout | output | 1 | Timer A timeout flag |
| b_timeout | output | 1 | Timer B timeout flag |
| a_out | output | 1 | Timer A output level |
| b_out | output | 1 | Timer B output level |

## Verification
The bench builds the block with A_W=8, B_W=12 and TICK_DIV=2. At these values a reload of 0 on timer A (256 ticks, 512 clocks) fits easily in the run. Several full alternation cycles, including the re-arm of A by B, also take only tens of clocks. The even prescaler ratio means a tick lost or doubled at a handover moves the edges that are checked by whole cycles.

// File: rtl/pp_seq_pkg.sv
package pp_seq_pkg;
  localparam logic [2:0] ADR_HOLD_A = 3'd0;
  localparam logic [2:0] ADR_HOLD_B = 3'd1;
  localparam logic [2:0] ADR_CTL_A  = 3'd2;
  localparam logic [2:0] ADR_CTL_B  = 3'd3;
  localparam logic [2:0] ADR_MODE   = 3'd4;

  localparam logic [1:0] SUB_NORMAL   = 2'b00;
  localparam logic [1:0] SUB_PINGPONG = 2'b01;

  localparam int CTL_EN     = 0;
  localparam int CTL_SINGLE = 1;
  localparam int CTL_CLR    = 2;
  localparam int CTL_INIT   = 3;
endpackage

// File: rtl/pp_tick_gen.sv
module pp_tick_gen #(
  parameter int DIV = 4
) (
  input  logic clk,
  input  logic rst_n,
  input  logic active,
  output logic tick
);
  localparam int CW = (DIV > 1) ? $clog2(DIV) : 1;

  generate
    if (DIV == 1) begin : g_direct
      assign tick = active;
    end else begin : g_div
      logic [CW-1:0] div_q;
      always_ff @(posedge clk) begin
        if (!rst_n || !active) div_q <= '0;
        else if (div_q == CW'(DIV - 1)) div_q <= '0;
        else div_q <= div_q + 1'b1;
      end
      assign tick = active && (div_q == CW'(DIV - 1));
    end
  endgenerate
endmodule

// File: rtl/pp_down_timer.sv
module pp_down_timer #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         tick,
  input  logic         hold_we,
  input  logic [W-1:0] hold_d,
  input  logic         ctl_we,
  input  logic         ctl_en,
  input  logic         ctl_single,
  input  logic         ctl_clr_to,
  input  logic         ctl_init,
  input  logic         hw_start,
  output logic         run,
  output logic         tc,
  output logic         timeout,
  output logic         out
);
  logic [W-1:0] hold_q, cnt_q;
  logic         run_q, run_d, single_q, init_q, to_q;

  assign tc = run_q && tick && (cnt_q == W'(1));

  always_comb begin
    run_d = run_q;
    if (ctl_we)                run_d = ctl_en;
    else if (hw_start)         run_d = 1'b1;
    else if (tc && single_q)   run_d = 1'b0;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      hold_q   <= '0;
      cnt_q    <= '0;
      run_q    <= 1'b0;
      single_q <= 1'b0;
      init_q   <= 1'b0;
      to_q     <= 1'b0;
    end else begin
      run_q <= run_d;
      if (hold_we) hold_q <= hold_d;
      if (ctl_we) begin
        single_q <= ctl_single;
        init_q   <= ctl_init;
      end
      if (run_d && !run_q)      cnt_q <= hold_q;
      else if (run_q && tick)   cnt_q <= (cnt_q == W'(1)) ? hold_q : cnt_q - 1'b1;
      if (tc)                       to_q <= 1'b1;
      else if (ctl_we && ctl_clr_to) to_q <= 1'b0;
    end
  end

  assign run     = run_q;
  assign timeout = to_q;
  assign out     = run_q ? ~init_q : init_q;

  // R3
  timeout_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
    tc |=> to_q);
  // R4
  single_stop_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (tc && single_q && !ctl_we && !hw_start) |=> !run_q);
  // R9
  start_source_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(run_q) |-> ($past(ctl_we) || $past(hw_start)));
endmodule

// File: rtl/pp_timer_seq.sv
module pp_timer_seq
  import pp_seq_pkg::*;
#(
  parameter int A_W      = 8,
  parameter int B_W      = 16,
  parameter int TICK_DIV = 4
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           cfg_we,
  input  logic [2:0]     cfg_addr,
  input  logic [B_W-1:0] cfg_wdata,
  output logic           a_run,
  output logic           b_run,
  output logic           a_timeout,
  output logic           b_timeout,
  output logic           a_out,
  output logic           b_out
);
  logic       tick, a_tc, b_tc, pp;
  logic [1:0] mode_q;

  always_ff @(posedge clk) begin
    if (!rst_n) mode_q <= SUB_NORMAL;
    else if (cfg_we && cfg_addr == ADR_MODE) mode_q <= cfg_wdata[1:0];
  end

  assign pp = (mode_q == SUB_PINGPONG);

  pp_tick_gen #(.DIV(TICK_DIV)) u_tick (
    .clk(clk), .rst_n(rst_n), .active(a_run | b_run), .tick(tick)
  );

  pp_down_timer #(.W(A_W)) u_tmr_a (
    .clk(clk), .rst_n(rst_n), .tick(tick),
    .hold_we(cfg_we && cfg_addr == ADR_HOLD_A), .hold_d(cfg_wdata[A_W-1:0]),
    .ctl_we(cfg_we && cfg_addr == ADR_CTL_A),
    .ctl_en(cfg_wdata[CTL_EN]), .ctl_single(cfg_wdata[CTL_SINGLE]),
    .ctl_clr_to(cfg_wdata[CTL_CLR]), .ctl_init(cfg_wdata[CTL_INIT]),
    .hw_start(pp && b_tc),
    .run(a_run), .tc(a_tc), .timeout(a_timeout), .out(a_out)
  );

  pp_down_timer #(.W(B_W)) u_tmr_b (
    .clk(clk), .rst_n(rst_n), .tick(tick),
    .hold_we(cfg_we && cfg_addr == ADR_HOLD_B), .hold_d(cfg_wdata),
    .ctl_we(cfg_we && cfg_addr == ADR_CTL_B),
    .ctl_en(cfg_wdata[CTL_EN]), .ctl_single(cfg_wdata[CTL_SINGLE]),
    .ctl_clr_to(cfg_wdata[CTL_CLR]), .ctl_init(cfg_wdata[CTL_INIT]),
    .hw_start(pp && a_tc),
    .run(b_run), .tc(b_tc), .timeout(b_timeout), .out(b_out)
  );

  // R6
  handover_ab_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (a_tc && pp && !cfg_we) |=> b_run);
  // R7
  handover_ba_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (b_tc && pp && !cfg_we) |=> a_run);
  // R8
  normal_no_handover_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (a_tc && !pp && !cfg_we) |=> !$rose(b_run));
endmodule

// File: tb/pp_timer_seq_tb_top.sv
module pp_timer_seq_tb_top;
  localparam int A_W = 8, B_W = 12, DIV = 2;

  logic clk = 1'b0, rst_n = 1'b0, cfg_we = 1'b0;
  logic [2:0] cfg_addr = '0;
  logic [B_W-1:0] cfg_wdata = '0;
  logic a_run, b_run, a_timeout, b_timeout, a_out, b_out;
  int checks = 0, fails = 0;
  bit done = 0;

  always #2.5 clk = ~clk;

  pp_timer_seq #(.A_W(A_W), .B_W(B_W), .TICK_DIV(DIV)) dut_i (
    .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_addr(cfg_addr),
    .cfg_wdata(cfg_wdata), .a_run(a_run), .b_run(b_run),
    .a_timeout(a_timeout), .b_timeout(b_timeout), .a_out(a_out), .b_out(b_out)
  );

  task automatic check(string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  // called at a falling edge; write lands on the next rising edge
  task automatic wr(logic [2:0] a, logic [B_W-1:0] d);
    cfg_we = 1'b1; cfg_addr = a; cfg_wdata = d;
    @(negedge clk);
    cfg_we = 1'b0;
  endtask

  task automatic step(int n);
    repeat (n) @(negedge clk);
  endtask

  function automatic logic [B_W-1:0] ctl(bit en, bit single, bit clr, bit init);
    return B_W'({init, clr, single, en});
  endfunction

  task automatic t_reset;
    check("R1 a_run", a_run, 0);       check("R1 b_run", b_run, 0);
    check("R1 a_timeout", a_timeout, 0); check("R1 b_timeout", b_timeout, 0);
    check("R1 a_out", a_out, 0);       check("R1 b_out", b_out, 0);
  endtask

  task automatic t_single_normal;
    wr(0, 5); wr(2, ctl(0, 1, 0, 0));
    wr(2, ctl(1, 1, 0, 0));
    check("R10 a_out running", a_out, 1);
    step(5 * DIV - 1);
    check("R2 a_run before tc", a_run, 1);
    check("R3 a_timeout before tc", a_timeout, 0);
    step(1);
    check("R4 a_run after tc", a_run, 0);
    check("R3 a_timeout at tc", a_timeout, 1);
    check("R4 b_run not started", b_run, 0);
    check("R10 a_out stopped", a_out, 0);
    step(3);
    check("R3 a_timeout held", a_timeout, 1);
    wr(2, ctl(0, 1, 1, 0));
    check("R3 a_timeout cleared", a_timeout, 0);
  endtask

  task automatic t_hold_zero;
    wr(0, 0); wr(2, ctl(1, 1, 0, 0));
    step(256 * DIV - 1);
    check("R2 zero reload still running", a_run, 1);
    step(1);
    check("R2 zero reload stopped", a_run, 0);
    wr(2, ctl(0, 1, 1, 0));
  endtask

  task automatic t_modulo;
    wr(0, 2); wr(2, ctl(1, 0, 0, 0));
    step(2 * DIV);
    check("R5 first tc flag", a_timeout, 1);
    check("R5 still running", a_run, 1);
    wr(2, ctl(1, 0, 1, 0));
    check("R5 flag cleared", a_timeout, 0);
    step(2);
    check("R5 before second tc", a_timeout, 0);
    step(1);
    check("R5 second tc flag", a_timeout, 1);
    wr(2, ctl(0, 0, 1, 0));
    check("R5 stopped by write", a_run, 0);
  endtask

  task automatic t_output_init;
    wr(3, ctl(0, 1, 0, 1));
    check("R10 b_out idle init 1", b_out, 1);
    wr(1, 3); wr(3, ctl(1, 1, 0, 1));
    check("R10 b_out running", b_out, 0);
    step(3 * DIV);
    check("R10 b_out after stop", b_out, 1);
    check("R4 a_run untouched", a_run, 0);
    wr(3, ctl(0, 1, 1, 0));
  endtask

  task automatic t_pingpong;
    wr(0, 3); wr(1, 5);
    wr(2, ctl(0, 1, 1, 0)); wr(3, ctl(0, 1, 1, 0));
    wr(4, 2'b01);
    wr(2, ctl(1, 1, 0, 0));
    step(5);
    check("R6 a running", a_run, 1); check("R6 b idle", b_run, 0);
    step(1);
    check("R6 a stopped", a_run, 0); check("R6 b started", b_run, 1);
    check("R6 a_timeout", a_timeout, 1);
    step(9);
    check("R7 b still running", b_run, 1); check("R7 a idle", a_run, 0);
    step(1);
    check("R7 a restarted", a_run, 1); check("R7 b stopped", b_run, 0);
    check("R7 b_timeout", b_timeout, 1);
    wr(4, 2'b00);
    step(4);
    check("R8 a finishing", a_run, 1);
    step(1);
    check("R8 a done", a_run, 0); check("R8 b not started", b_run, 0);
    step(20);
    check("R8 both idle a", a_run, 0); check("R8 both idle b", b_run, 0);
  endtask

  task automatic t_sw_halt;
    wr(2, ctl(0, 1, 1, 0)); wr(3, ctl(0, 1, 1, 0));
    wr(4, 2'b01);
    wr(2, ctl(1, 1, 0, 0));
    step(6);
    check("R9 b took over", b_run, 1);
    wr(3, ctl(0, 1, 0, 0));
    check("R9 b halted", b_run, 0); check("R9 a halted", a_run, 0);
    step(30);
    check("R9 a stays idle", a_run, 0); check("R9 b stays idle", b_run, 0);
    check("R11 b_timeout untouched", b_timeout, 0);
  endtask

  initial begin
    step(4);
    rst_n = 1'b1;
    t_reset();
    t_single_normal();
    t_hold_zero();
    t_modulo();
    t_output_init();
    t_pingpong();
    t_sw_halt();
    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      fails++;
      $display("FAIL watchdog: actual hung expected finish");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end
endmodule